// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Core

This block is a watchdog counter that runs in two stages. Once enabled, it counts down a first interval. When that interval runs out it signals an early warning on one of two interrupt pulses, then at once starts a second interval. If the second interval also runs out and reboot is allowed, the block pulses a system-reset action. At the same edge it sets a sticky flag, so that software can later see that the watchdog caused the last reset. Software keeps the system alive by strobing a reload input, which restarts the first interval.

Each stage length is a 20-bit preload scaled by a shift. The fast scale shifts by 5 and the slow scale shifts by 15, and the count advances by one per clock. A lock bit freezes the enable, free-run and lock settings until reset. In free-run mode the block begins the first stage again after the second stage expires. A plain settings port takes the place of any register bus or unlock handshake.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset no pulse is output, `stage2_o` is 0, `prev_wd_rst_o` is 0, and both preloads are 0xFFFFF. The reset mode is: reboot enabled, slow scale, IRQ type, free-run off, unlocked, disabled.
- R2: A settings write that takes the enable from 0 to 1 starts stage 1. An event at the end of a stage is output exactly L clock edges after the stage starts. L is preload << 5 when `mode_fast_i` = 1, and preload << 15 when it is 0. A stage with L = 0 lasts one cycle.
- R3: When stage 1 expires, the interrupt type field selects the pulse: 0 gives `irq_o`, 2 gives `smi_o`, and 1 or 3 give no pulse. `stage2_o` becomes 1, and stage 2 starts from the second preload.
- R4: When stage 2 expires with `mode_noboot_i` = 0 at the last write, `rst_act_o` pulses and `prev_wd_rst_o` is set on the same edge. With `mode_noboot_i` = 1, neither happens.
- R5: After stage 2 expires, stage 1 restarts if free-run is set. If free-run is clear, counting stops.
- R6: `kick_i` restarts stage 1 from the first preload while enabled, and has no effect while disabled. A kick on the same edge as an expiry cancels that expiry's pulse.
- R7: Writing enable = 0 (while unlocked) stops counting, and no further pulse is output.
- R8: Once lock is written as 1, later writes to lock, enable and free-run are ignored until reset.
- R9: `prev_wd_rst_o` stays set until `flag_clr_i` is sampled. If a set and a clear fall on the same edge, the set wins.
- R10: `irq_o`, `smi_o` and `rst_act_o` are single-cycle pulses, and at most one is high in any cycle.
- R11: A preload write does not change the stage already running. It takes effect at the next start of that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one count step per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Write strobe for the mode fields |
| mode_noboot_i | input | 1 | 1 = no reset action at stage 2 expiry |
| mode_fast_i | input | 1 | 1 = fast scale (shift 5), 0 = slow scale (shift 15) |
| mode_int_i | input | 2 | Stage 1 interrupt type: 0 IRQ, 2 SMI, 1/3 none |
| ctl_we_i | input | 1 | Write strobe for lock, enable and free-run |
| ctl_lock_i | input | 1 | Lock value to write |
| ctl_en_i | input | 1 | Enable value to write |
| ctl_free_i | input | 1 | Free-run value to write |
| pre1_we_i | input | 1 | Write strobe for the first preload |
| pre2_we_i | input | 1 | Write strobe for the second preload |
| pre_data_i | input | PRELOAD_W (20) | Preload write data |
| kick_i | input | 1 | Keep-alive reload strobe |
| flag_clr_i | input | 1 | Clears the previous-reset flag |
| irq_o | output | 1 | Stage 1 interrupt pulse, IRQ type |
| smi_o | output | 1 | Stage 1 interrupt pulse, SMI type |
| rst_act_o | output | 1 | System-reset action pulse |
| prev_wd_rst_o | output | 1 | Sticky flag: the watchdog caused a reset |
| stage2_o | output | 1 | 0 = stage 1 current, 1 = stage 2 current |

## Verification
A keep-alive strobe and a stage expiry can land on the same clock edge. The bench provokes this by asserting `kick_i` on exactly the edge where stage 1's count runs out. It then expects no interrupt there, and a full new stage 1 before the next one. The reset-action edge that sets the previous-reset flag is also driven together with `flag_clr_i`, and the flag must read 1 afterwards. A scoreboard holds every expected pulse with its exact cycle, so a pulse that comes early, late or without cause is reported.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    INT_IRQ  = 2'd0,
    INT_RSVD = 2'd1,
    INT_SMI  = 2'd2,
    INT_NONE = 2'd3
  } int_sel_e;

  typedef struct packed {
    logic     reboot_en;
    logic     fast;
    int_sel_e int_sel;
  } mode_s;

  typedef struct packed {
    logic locked;
    logic en;
    logic free_run;
  } ctl_s;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic                 mode_noboot_i,
  input  logic                 mode_fast_i,
  input  logic [1:0]           mode_int_i,
  input  logic                 ctl_we_i,
  input  logic                 ctl_lock_i,
  input  logic                 ctl_en_i,
  input  logic                 ctl_free_i,
  input  logic                 pre1_we_i,
  input  logic                 pre2_we_i,
  input  logic [PRELOAD_W-1:0] pre_data_i,
  output mode_s                mode_o,
  output ctl_s                 ctl_o,
  output logic                 start_o,
  output logic                 stop_o,
  output logic [PRELOAD_W-1:0] pre1_o,
  output logic [PRELOAD_W-1:0] pre2_o
);
  localparam logic [PRELOAD_W-1:0] PRE_RST = '1;

  mode_s mode_q;
  ctl_s  ctl_q;
  logic  ctl_ok;

  assign ctl_ok  = ctl_we_i && !ctl_q.locked;
  assign start_o = ctl_ok && ctl_en_i && !ctl_q.en;
  assign stop_o  = ctl_ok && !ctl_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '{reboot_en: 1'b1, fast: 1'b0, int_sel: INT_IRQ};
      ctl_q  <= '0;
      pre1_o <= PRE_RST;
      pre2_o <= PRE_RST;
    end else begin
      if (mode_we_i)
        mode_q <= '{reboot_en: !mode_noboot_i, fast: mode_fast_i,
                    int_sel: int_sel_e'(mode_int_i)};
      if (ctl_ok)
        ctl_q <= '{locked: ctl_lock_i, en: ctl_en_i, free_run: ctl_free_i};
      if (pre1_we_i) pre1_o <= pre_data_i;
      if (pre2_we_i) pre2_o <= pre_data_i;
    end
  end

  assign mode_o = mode_q;
  assign ctl_o  = ctl_q;

  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.locked |=> ctl_q.locked && $stable(ctl_q.en) && $stable(ctl_q.free_run))
    else $error("p_lock_sticky_r8");
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int PRELOAD_W = 20,
  parameter int SLOW_SH   = 15,
  parameter int FAST_SH   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 kick_i,
  input  logic                 en_i,
  input  logic                 free_i,
  input  logic                 fast_i,
  input  logic [PRELOAD_W-1:0] pre1_i,
  input  logic [PRELOAD_W-1:0] pre2_i,
  output logic                 exp1_o,
  output logic                 exp2_o,
  output logic                 stage2_o,
  output logic                 run_o
);
  localparam int MAX_SH = (SLOW_SH > FAST_SH) ? SLOW_SH : FAST_SH;
  localparam int CNT_W  = PRELOAD_W + MAX_SH;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, stage_q;
  logic             restart, at_end;

  function automatic logic [CNT_W-1:0] scale(input logic [PRELOAD_W-1:0] p,
                                             input logic fast);
    logic [CNT_W-1:0] v;
    v = CNT_W'(p);
    return fast ? (v << FAST_SH) : (v << SLOW_SH);
  endfunction

  assign restart = start_i || (kick_i && en_i);
  // count of 1 (or a zero-length load) ends the stage on the next edge
  assign at_end  = run_q && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      stage_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (restart) begin
      run_q   <= 1'b1;
      stage_q <= 1'b0;
      cnt_q   <= scale(pre1_i, fast_i);
    end else if (at_end) begin
      if (!stage_q) begin
        stage_q <= 1'b1;
        cnt_q   <= scale(pre2_i, fast_i);
      end else if (free_i) begin
        stage_q <= 1'b0;
        cnt_q   <= scale(pre1_i, fast_i);
      end else begin
        run_q <= 1'b0;
      end
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign exp1_o   = at_end && !stage_q && !restart && !stop_i;
  assign exp2_o   = at_end &&  stage_q && !restart && !stop_i;
  assign stage2_o = stage_q;
  assign run_o    = run_q;

  p_idle_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !run_q)
    else $error("p_idle_when_off_r7");

  p_kick_restarts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && en_i && !stop_i) |=> run_q && !stage_q)
    else $error("p_kick_restarts_r6");
endmodule

// File: rtl/wdog_events.sv
module wdog_events
  import wdog_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     exp1_i,
  input  logic     exp2_i,
  input  int_sel_e int_sel_i,
  input  logic     reboot_en_i,
  input  logic     flag_clr_i,
  output logic     irq_o,
  output logic     smi_o,
  output logic     rst_act_o,
  output logic     flag_o
);
  logic boot_hit;
  assign boot_hit = exp2_i && reboot_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      smi_o     <= 1'b0;
      rst_act_o <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      irq_o     <= exp1_i && (int_sel_i == INT_IRQ);
      smi_o     <= exp1_i && (int_sel_i == INT_SMI);
      rst_act_o <= boot_hit;
      if (boot_hit)        flag_o <= 1'b1;  // set beats clear
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end

  p_one_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, smi_o, rst_act_o}))
    else $error("p_one_event_r10");

  p_irq_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || smi_o) |=> !irq_o && !smi_o)
    else $error("p_irq_single_r10");

  p_flag_with_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act_o |-> flag_o)
    else $error("p_flag_with_reset_r4");

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o)
    else $error("p_flag_sticky_r9");
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int PRELOAD_W = 20,
  parameter int SLOW_SH   = 15,
  parameter int FAST_SH   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic                 mode_noboot_i,
  input  logic                 mode_fast_i,
  input  logic [1:0]           mode_int_i,
  input  logic                 ctl_we_i,
  input  logic                 ctl_lock_i,
  input  logic                 ctl_en_i,
  input  logic                 ctl_free_i,
  input  logic                 pre1_we_i,
  input  logic                 pre2_we_i,
  input  logic [PRELOAD_W-1:0] pre_data_i,
  input  logic                 kick_i,
  input  logic                 flag_clr_i,
  output logic                 irq_o,
  output logic                 smi_o,
  output logic                 rst_act_o,
  output logic                 prev_wd_rst_o,
  output logic                 stage2_o
);
  mode_s                mode;
  ctl_s                 ctl;
  logic                 start, stop, exp1, exp2, run;
  logic [PRELOAD_W-1:0] pre1, pre2;

  wdog_cfg #(.PRELOAD_W(PRELOAD_W)) u_cfg (
    .clk_i, .rst_ni, .mode_we_i, .mode_noboot_i, .mode_fast_i, .mode_int_i,
    .ctl_we_i, .ctl_lock_i, .ctl_en_i, .ctl_free_i, .pre1_we_i, .pre2_we_i,
    .pre_data_i, .mode_o(mode), .ctl_o(ctl), .start_o(start), .stop_o(stop),
    .pre1_o(pre1), .pre2_o(pre2)
  );

  wdog_counter #(.PRELOAD_W(PRELOAD_W), .SLOW_SH(SLOW_SH), .FAST_SH(FAST_SH)) u_cnt (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .kick_i,
    .en_i(ctl.en), .free_i(ctl.free_run), .fast_i(mode.fast),
    .pre1_i(pre1), .pre2_i(pre2), .exp1_o(exp1), .exp2_o(exp2),
    .stage2_o, .run_o(run)
  );

  wdog_events u_evt (
    .clk_i, .rst_ni, .exp1_i(exp1), .exp2_i(exp2), .int_sel_i(mode.int_sel),
    .reboot_en_i(mode.reboot_en), .flag_clr_i, .irq_o, .smi_o, .rst_act_o,
    .flag_o(prev_wd_rst_o)
  );

  p_warn_enters_stage2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || smi_o) |-> stage2_o)
    else $error("p_warn_enters_stage2_r3");

  p_no_event_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !irq_o && !smi_o && !rst_act_o)
    else $error("p_no_event_idle_r7");
endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 20;
  localparam int K_IRQ = 0, K_SMI = 1, K_RST = 2;

  logic clk = 0, rst_n = 0;
  logic mode_we = 0, mode_noboot = 0, mode_fast = 0;
  logic [1:0] mode_int = 0;
  logic ctl_we = 0, ctl_lock = 0, ctl_en = 0, ctl_free = 0;
  logic pre1_we = 0, pre2_we = 0;
  logic [PW-1:0] pre_data = 0;
  logic kick = 0, flag_clr = 0;
  logic irq, smi, rst_act, prev_flag, stage2;

  int cyc = 0, total = 0, bad = 0;
  bit done = 0;

  typedef struct { int kind; int at; } ev_t;
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_noboot_i(mode_noboot),
    .mode_fast_i(mode_fast), .mode_int_i(mode_int), .ctl_we_i(ctl_we),
    .ctl_lock_i(ctl_lock), .ctl_en_i(ctl_en), .ctl_free_i(ctl_free),
    .pre1_we_i(pre1_we), .pre2_we_i(pre2_we), .pre_data_i(pre_data),
    .kick_i(kick), .flag_clr_i(flag_clr), .irq_o(irq), .smi_o(smi),
    .rst_act_o(rst_act), .prev_wd_rst_o(prev_flag), .stage2_o(stage2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic string kname(input int k);
    return (k == K_IRQ) ? "irq" : (k == K_SMI) ? "smi" : "rst_act";
  endfunction

  task automatic see_pulse(input int k);
    if (q.size() > 0 && q[0].kind == k && q[0].at == cyc) begin
      total++;
      void'(q.pop_front());
    end else begin
      total++; bad++;
      $display("FAIL R2/R3/R4/R10: unexpected %s pulse actual_cycle=%0d expected_cycle=%0d",
               kname(k), cyc, (q.size() > 0) ? q[0].at : -1);
    end
  endtask

  // monitor: compare produced pulses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        total++; bad++;
        $display("FAIL R2/R3/R4: missing %s pulse actual=none expected_cycle=%0d",
                 kname(q[0].kind), q[0].at);
        void'(q.pop_front());
      end
      if (irq)     see_pulse(K_IRQ);
      if (smi)     see_pulse(K_SMI);
      if (rst_act) see_pulse(K_RST);
    end
  end

  task automatic expect_ev(input int k, input int at);
    ev_t e; e.kind = k; e.at = at; q.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr_mode(input bit noboot, input bit fast, input logic [1:0] t);
    mode_we = 1; mode_noboot = noboot; mode_fast = fast; mode_int = t;
    @(posedge clk); #1; mode_we = 0;
  endtask

  task automatic wr_ctl(input bit lk, input bit en, input bit fr);
    ctl_we = 1; ctl_lock = lk; ctl_en = en; ctl_free = fr;
    @(posedge clk); #1; ctl_we = 0;
  endtask

  task automatic wr_pre(input bit second, input int v);
    pre_data = PW'(v); pre1_we = !second; pre2_we = second;
    @(posedge clk); #1; pre1_we = 0; pre2_we = 0;
  endtask

  task automatic do_kick();
    kick = 1; @(posedge clk); #1; kick = 0;
  endtask

  task automatic do_clr();
    flag_clr = 1; @(posedge clk); #1; flag_clr = 0;
  endtask

  task automatic queue_empty(input string req);
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(stage2 == 0, "R1 stage", stage2, 0);
    chk(prev_flag == 0, "R1 flag", prev_flag, 0);
    chk({irq, smi, rst_act} == 0, "R1 pulses", {irq, smi, rst_act}, 0);

    // R2 R3 R4 R5: fast scale, IRQ, reboot enabled, no free-run
    wr_pre(0, 3); wr_pre(1, 2);          // L1=96, L2=64
    wr_mode(0, 1, 2'd0);
    wr_ctl(0, 1, 0); n = cyc;
    expect_ev(K_IRQ, n + 96); expect_ev(K_RST, n + 160);
    wait_until(n + 97);
    chk(stage2 == 1, "R3 stage2 after expiry", stage2, 1);
    wait_until(n + 161);
    chk(prev_flag == 1, "R4 flag set", prev_flag, 1);
    wait_until(n + 400);
    queue_empty("R5 stopped without free-run");
    do_clr();
    chk(prev_flag == 0, "R9 flag cleared", prev_flag, 0);

    // R3 SMI type, R4 reboot disabled, R6 kick restarts a stopped stage
    wr_mode(1, 1, 2'd2);
    do_kick(); n = cyc;
    expect_ev(K_SMI, n + 96);
    wait_until(n + 300);
    queue_empty("R4 no reset action when disabled");
    chk(prev_flag == 0, "R4 flag stays clear", prev_flag, 0);

    // R3 type none, R5 free-run, R7 disable stops
    wr_mode(0, 1, 2'd3);
    wr_ctl(0, 0, 0);
    wr_ctl(0, 1, 1); n = cyc;
    expect_ev(K_RST, n + 160); expect_ev(K_RST, n + 320);
    wait_until(n + 330);
    queue_empty("R5 free-run restart");
    wr_ctl(0, 0, 0); n = cyc;
    wait_until(n + 400);
    queue_empty("R7 disable stops counting");
    do_clr();

    // R6 kick coinciding with stage 1 expiry; R9 set beats clear
    wr_mode(0, 1, 2'd0);
    wr_ctl(0, 1, 0); n = cyc;
    wait_until(n + 95);
    do_kick();                            // sampled at edge n+96
    expect_ev(K_IRQ, n + 192); expect_ev(K_RST, n + 256);
    wait_until(n + 255);
    flag_clr = 1; @(posedge clk); #1 flag_clr = 0;   // edge n+256
    wait_until(n + 256);
    chk(prev_flag == 1, "R9 set wins over clear", prev_flag, 1);
    wait_until(n + 300);
    queue_empty("R6 kick cancels expiry");
    do_clr();

    // R6 kick ignored while disabled
    wr_ctl(0, 0, 0);
    do_kick(); n = cyc;
    wait_until(n + 300);
    queue_empty("R6 kick while disabled");
    chk(stage2 == 1, "R6 stage unchanged by ignored kick", stage2, 1);

    // R11 preload write mid-stage takes effect at next start
    wr_ctl(0, 1, 0); n = cyc;
    expect_ev(K_IRQ, n + 96); expect_ev(K_RST, n + 160);
    wait_until(n + 10);
    wr_pre(0, 1);
    wait_until(n + 200);
    queue_empty("R11 running stage unchanged");
    wr_ctl(0, 0, 0);
    wr_ctl(0, 1, 0); n = cyc;
    expect_ev(K_IRQ, n + 32); expect_ev(K_RST, n + 96);
    wait_until(n + 150);
    queue_empty("R11 new preload used");
    do_clr();

    // R8 lock freezes enable/free-run/lock
    wr_ctl(0, 0, 0);
    wr_ctl(1, 1, 0); n = cyc;
    expect_ev(K_IRQ, n + 32); expect_ev(K_RST, n + 96);
    wait_until(n + 5);
    wr_ctl(0, 0, 1);
    wait_until(n + 300);
    queue_empty("R8 writes ignored after lock");
    chk(prev_flag == 1, "R8 locked run reached reset action", prev_flag, 1);

    // R1 reset clears lock and flag; R2 slow scale
    rst_n = 0; @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(prev_flag == 0, "R1 flag after reset", prev_flag, 0);
    chk(stage2 == 0, "R1 stage after reset", stage2, 0);
    wr_pre(0, 1); wr_pre(1, 1);
    wr_ctl(0, 1, 0); n = cyc;             // reset mode: slow, IRQ, reboot
    expect_ev(K_IRQ, n + 32768); expect_ev(K_RST, n + 65536);
    wait_until(n + 65540);
    queue_empty("R2 slow scale timing");
    chk(prev_flag == 1, "R1 reset default reboot enabled", prev_flag, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule